// File: doc/BRIEF.md
# DAC Conversion Start and Sample Controller

This block is the digital side of a 12-bit digital-to-analog converter. Software programs it through a small word-addressed register bus. One register sets up the block, one holds the sample, one fires a software start and one reports status. When a conversion starts, the block converts the held sample into a 12-bit code and presents it to the analog converter together with a one-cycle load strobe. It then keeps a busy window open while the output settles, and raises a finish flag when that window closes.

The start event is chosen by a source multiplexer. In direct mode, a write to the sample register starts the conversion. In triggered mode, the start comes from a software kick, from a level or edge condition on a synchronised external pin, or from one of four timer pulses or two PWM pulses. A start taken from a hardware source can also raise a DMA request. That request stays pending until the sample register is written. If a further hardware start arrives while the request is still pending, the block flags a DMA under-run. The finish flag and the under-run flag each have their own interrupt enable.

Register words, by bus_addr: 0 control, 1 sample, 2 kick, 3 status. Control fields:
- bit 0: finish interrupt enable
- bit 1: under-run interrupt enable
- bit 2: DMA enable
- bit 3: left alignment
- bit 4: triggered mode
- bits 7:5: source select
- bits 9:8: pin condition
- bits 23:16: settle count

Top module: `dac_trigger_ctrl`

## Requirements
- R1: With control bit 3 clear, the code is sample bits 11:0. Sample bits 31:12 have no effect on the code.
- R2: With control bit 3 set, the code is sample bits 15:4. Sample bits 31:16 and 3:0 have no effect on the code.
- R3: With control bit 4 clear, a write to the sample word starts a conversion. dac_load is high for exactly one cycle, the second cycle after the write edge. dac_code holds the new code from that cycle until the next conversion.
- R4: With control bit 4 set and source 0, writing 1 to bit 0 of the kick word gives exactly one start. The kick word always reads as 0.
- R5: Source 1 uses the external pin after two synchronising flip-flops. Pin condition 0 fires on a low level, 1 on a high level, 2 on a falling edge and 3 on a rising edge. A held level starts a new conversion each time the previous conversion completes.
- R6: Sources 2 to 5 start on timer pulse tmr_evt[source-2]. Sources 6 and 7 start on PWM pulse pwm_evt[source-6]. Pulses from sources that are not selected have no effect.
- R7: After a start, busy (status bit 8) stays high for settle count + 1 cycles. A start that arrives while busy is ignored. The finish flag (status bit 0) sets in the cycle busy falls.
- R8: A start accepted from a hardware source (control bit 4 set, source not 0) while control bit 2 is set raises dma_req. dma_req stays high until a write to the sample word.
- R9: If such a hardware start is accepted while dma_req is still high, the under-run flag (status bit 1) sets.
- R10: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R11: irq is high when the finish flag is set with control bit 0 set, or when the under-run flag is set with control bit 1 set.
- R12: After reset, all registers, flags, dac_code, dac_load, dma_req and irq are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_evt | input | 4 | Timer event pulses |
| pwm_evt | input | 2 | PWM event pulses |
| dac_code | output | 12 | Code presented to the converter |
| dac_load | output | 1 | One-cycle load strobe for dac_code |
| dma_req | output | 1 | Pending DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that timer and PWM events are single-cycle pulses. They also assume that control is not rewritten while a pin edge is being detected, so that the selected source and pin condition stay constant around each start they judge. The stimulus drives every input on the falling clock edge. It pulses timer and PWM lines for one cycle, and it rewrites control only while the block is idle. The external pin changes freely, because the block treats it as asynchronous and synchronises it inside.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int WORD_W   = 32;
  localparam int CODE_W   = 12;
  localparam int SETTLE_W = 8;
  localparam int NUM_TMR  = 4;
  localparam int NUM_PWM  = 2;
  localparam int NUM_SRC  = 2 + NUM_TMR + NUM_PWM;
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int LEFT_LSB = 4;
  localparam int SETTLE_LSB = 16;

  typedef enum logic [SRC_W-1:0] {
    SRC_KICK = 3'd0, SRC_PIN = 3'd1,
    SRC_T0 = 3'd2, SRC_T1 = 3'd3, SRC_T2 = 3'd4, SRC_T3 = 3'd5,
    SRC_P0 = 3'd6, SRC_P1 = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    PIN_LOW = 2'd0, PIN_HIGH = 2'd1, PIN_FALL = 2'd2, PIN_RISE = 2'd3
  } pin_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_KICK = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic [SETTLE_W-1:0] settle;
    pin_e                pin_cond;
    src_e                src;
    logic                trig_en;
    logic                left;
    logic                dma_en;
    logic                udr_ie;
    logic                fin_ie;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.fin_ie   = w[0];
    c.udr_ie   = w[1];
    c.dma_en   = w[2];
    c.left     = w[3];
    c.trig_en  = w[4];
    c.src      = src_e'(w[7:5]);
    c.pin_cond = pin_e'(w[9:8]);
    c.settle   = w[SETTLE_LSB +: SETTLE_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[0]   = c.fin_ie;
    w[1]   = c.udr_ie;
    w[2]   = c.dma_en;
    w[3]   = c.left;
    w[4]   = c.trig_en;
    w[7:5] = c.src;
    w[9:8] = c.pin_cond;
    w[SETTLE_LSB +: SETTLE_W] = c.settle;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] stat_pack(input logic fin, input logic udr,
                                                  input logic busy);
    logic [WORD_W-1:0] w;
    w = '0;
    w[0] = fin;
    w[1] = udr;
    w[8] = busy;
    return w;
  endfunction

  function automatic logic [CODE_W-1:0] align_sample(input logic [WORD_W-1:0] d,
                                                      input logic left);
    return left ? d[LEFT_LSB +: CODE_W] : d[0 +: CODE_W];
  endfunction

  function automatic logic pin_hit(input pin_e cond, input logic now, input logic prev);
    case (cond)
      PIN_LOW:  return !now;
      PIN_HIGH: return now;
      PIN_FALL: return prev && !now;
      default:  return !prev && now;
    endcase
  endfunction
endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              fin_set,
  input  logic              udr_set,
  input  logic              busy,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] sample,
  output logic              data_wr,
  output logic              data_wr_q,
  output logic              kick_q,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [WORD_W-1:0] sample_q;
  logic              fin_q, udr_q;
  logic              ctrl_wr, kick_wr, stat_wr;

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign data_wr = bus_we && (bus_addr == A_DATA);
  assign kick_wr = bus_we && (bus_addr == A_KICK);
  assign stat_wr = bus_we && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      sample_q  <= '0;
      fin_q     <= 1'b0;
      udr_q     <= 1'b0;
      kick_q    <= 1'b0;
      data_wr_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_unpack(bus_wdata);
      if (data_wr) sample_q <= bus_wdata;
      kick_q    <= kick_wr && bus_wdata[0];
      data_wr_q <= data_wr;
      fin_q     <= fin_set || (fin_q && !(stat_wr && bus_wdata[0]));
      udr_q     <= udr_set || (udr_q && !(stat_wr && bus_wdata[1]));
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_pack(ctrl_q);
      A_DATA:  bus_rdata = sample_q;
      A_KICK:  bus_rdata = '0;
      default: bus_rdata = stat_pack(fin_q, udr_q, busy);
    endcase
  end

  assign ctrl   = ctrl_q;
  assign sample = sample_q;
  assign irq    = (fin_q && ctrl_q.fin_ie) || (udr_q && ctrl_q.udr_ie);

  // R7: the finish flag only rises on the cycle the busy window closes
  a_r7_finish_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> $fell(busy));
endmodule

// File: rtl/dacfe_trig.sv
module dacfe_trig
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_en,
  input  src_e               src,
  input  pin_e               pin_cond,
  input  logic               ext_pin,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic [NUM_PWM-1:0] pwm_evt,
  input  logic               kick,
  input  logic               data_wr_q,
  output logic               start_req,
  output logic               hw_src
);
  localparam int TMR_BASE = 2;
  localparam int PWM_BASE = TMR_BASE + NUM_TMR;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_now, pin_prev_q, pin_ev;
  logic [NUM_SRC-1:0]     evt_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= ext_pin;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign pin_now = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev_q <= 1'b0;
    else        pin_prev_q <= pin_now;
  end

  assign pin_ev = pin_hit(pin_cond, pin_now, pin_prev_q);

  always_comb begin
    evt_vec = '0;
    evt_vec[SRC_KICK] = kick;
    evt_vec[SRC_PIN]  = pin_ev;
    evt_vec[TMR_BASE +: NUM_TMR] = tmr_evt;
    evt_vec[PWM_BASE +: NUM_PWM] = pwm_evt;
  end

  assign start_req = trig_en ? evt_vec[src] : data_wr_q;
  assign hw_src    = trig_en && (src != SRC_KICK);

  // R5: a rising-edge start from the pin needs the synchronised pin to have just risen
  a_r5_rise_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en && src == SRC_PIN && pin_cond == PIN_RISE && start_req) |-> $rose(pin_now));
endmodule

// File: rtl/dacfe_conv.sv
module dacfe_conv
  import dacfe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                hw_src,
  input  logic [SETTLE_W-1:0] settle,
  input  logic                left,
  input  logic                dma_en,
  input  logic [WORD_W-1:0]   sample,
  input  logic                data_wr,
  output logic                busy,
  output logic [CODE_W-1:0]   dac_code,
  output logic                dac_load,
  output logic                dma_req,
  output logic                fin_set,
  output logic                udr_set
);
  logic                busy_q, load_q, dma_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [CODE_W-1:0]   code_q;
  logic                start, dma_arm;

  assign start   = start_req && !busy_q;
  assign dma_arm = start && hw_src && dma_en;
  assign fin_set = busy_q && (cnt_q == '0);
  assign udr_set = dma_arm && dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
      load_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      load_q <= start;
      if (start) begin
        code_q <= align_sample(sample, left);
        busy_q <= 1'b1;
        cnt_q  <= settle;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      if (dma_arm)      dma_q <= 1'b1;
      else if (data_wr) dma_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign dac_code = code_q;
  assign dac_load = load_q;
  assign dma_req  = dma_q;

  // R7: the code cannot change while a conversion is settling
  a_r7_code_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(code_q));
  // R3: every load strobe opens a busy window
  a_r3_load_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> busy_q);
  // R8: a request only appears when DMA was enabled
  a_r8_dma_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_q) |-> $past(dma_en));
  // R8: a request only appears together with a load strobe
  a_r8_dma_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_q) |-> load_q);
endmodule

// File: rtl/dac_trigger_ctrl.sv
module dac_trigger_ctrl
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [1:0]         bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic               ext_pin,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic [NUM_PWM-1:0] pwm_evt,
  output logic [CODE_W-1:0]  dac_code,
  output logic               dac_load,
  output logic               dma_req,
  output logic               irq
);
  ctrl_t             ctrl;
  logic [WORD_W-1:0] sample;
  logic              data_wr, data_wr_q, kick_q;
  logic              fin_set, udr_set, busy;
  logic              start_req, hw_src;

  dacfe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fin_set(fin_set),
    .udr_set(udr_set), .busy(busy), .ctrl(ctrl), .sample(sample),
    .data_wr(data_wr), .data_wr_q(data_wr_q), .kick_q(kick_q), .irq(irq)
  );

  dacfe_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_en(ctrl.trig_en), .src(ctrl.src),
    .pin_cond(ctrl.pin_cond), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
    .pwm_evt(pwm_evt), .kick(kick_q), .data_wr_q(data_wr_q),
    .start_req(start_req), .hw_src(hw_src)
  );

  dacfe_conv u_conv (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .hw_src(hw_src),
    .settle(ctrl.settle), .left(ctrl.left), .dma_en(ctrl.dma_en),
    .sample(sample), .data_wr(data_wr), .busy(busy), .dac_code(dac_code),
    .dac_load(dac_load), .dma_req(dma_req), .fin_set(fin_set), .udr_set(udr_set)
  );
endmodule

// File: tb/dac_trigger_ctrl_bench.sv
`timescale 1ns/1ps
module dac_trigger_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_pin = 1'b0;
  logic [3:0]  tmr_evt = '0;
  logic [1:0]  pwm_evt = '0;
  logic [11:0] dac_code;
  logic        dac_load, dma_req, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dac_trigger_ctrl u_dac_trigger_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .tmr_evt(tmr_evt), .pwm_evt(pwm_evt), .dac_code(dac_code),
    .dac_load(dac_load), .dma_req(dma_req), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_data;
  logic        m_kick, m_wrq, m_fin, m_udr, m_busy, m_load, m_dma;
  logic        m_s1, m_s2, m_prev;
  int          m_cnt;
  logic [11:0] m_code;

  task automatic model_step();
    bit te, ev, st, hw, dwr, fs, arm, us, clr, hit;
    int src, cond;
    te = m_ctrl[4]; src = int'(m_ctrl[7:5]); cond = int'(m_ctrl[9:8]);
    case (cond)
      0: hit = !m_s2;
      1: hit = m_s2;
      2: hit = m_prev && !m_s2;
      default: hit = !m_prev && m_s2;
    endcase
    if (src == 0) ev = m_kick;
    else if (src == 1) ev = hit;
    else if (src < 6) ev = tmr_evt[src-2];
    else ev = pwm_evt[src-6];
    st  = (te ? ev : m_wrq) && !m_busy;
    hw  = te && src != 0;
    dwr = bus_we && bus_addr == 2'd1;
    clr = bus_we && bus_addr == 2'd3;
    fs  = m_busy && m_cnt == 0;
    arm = st && hw && m_ctrl[2];
    us  = arm && m_dma;
    m_fin = fs || (m_fin && !(clr && bus_wdata[0]));
    m_udr = us || (m_udr && !(clr && bus_wdata[1]));
    m_load = st;
    if (st) m_code = m_ctrl[3] ? m_data[15:4] : m_data[11:0];
    if (st) begin m_busy = 1; m_cnt = int'(m_ctrl[23:16]); end
    else if (m_busy) begin
      if (m_cnt == 0) m_busy = 0; else m_cnt = m_cnt - 1;
    end
    if (arm) m_dma = 1; else if (dwr) m_dma = 0;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    m_kick = bus_we && bus_addr == 2'd2 && bus_wdata[0];
    m_wrq  = dwr;
    if (bus_we && bus_addr == 2'd0) m_ctrl = bus_wdata & 32'h00FF_03FF;
    if (dwr) m_data = bus_wdata;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_data = '0; m_kick = 0; m_wrq = 0; m_fin = 0; m_udr = 0;
      m_busy = 0; m_load = 0; m_dma = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_cnt = 0; m_code = '0;
    end else model_step();
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, after inputs for this cycle are applied
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(dac_code === m_code, "R1/R2/R6 dac_code", int'(dac_code), int'(m_code));
      check(dac_load === m_load, "R3/R4/R5 dac_load", int'(dac_load), int'(m_load));
      check(dma_req === m_dma, "R8 dma_req", int'(dma_req), int'(m_dma));
      check(irq === ((m_fin && m_ctrl[0]) || (m_udr && m_ctrl[1])), "R11 irq",
            int'(irq), int'((m_fin && m_ctrl[0]) || (m_udr && m_ctrl[1])));
      if (bus_addr == 2'd3)
        check(bus_rdata === {23'd0, m_busy, 6'd0, m_udr, m_fin}, "R7/R9/R10 status",
              int'(bus_rdata), int'({23'd0, m_busy, 6'd0, m_udr, m_fin}));
      if (bus_addr == 2'd2)
        check(bus_rdata === 32'd0, "R4 kick readback", int'(bus_rdata), 0);
    end
  end

  function automatic logic [31:0] mk_ctrl(input bit fie, input bit uie, input bit dma,
      input bit left, input bit te, input int src, input int cond, input int settle);
    return {8'd0, 8'(settle), 6'd0, 2'(cond), 3'(src), te, left, dma, uie, fie};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 2'd3; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tmr(input int i);
    @(negedge clk); tmr_evt[i] = 1'b1;
    @(negedge clk); tmr_evt = '0;
  endtask

  task automatic pulse_pwm(input int i);
    @(negedge clk); pwm_evt[i] = 1'b1;
    @(negedge clk); pwm_evt = '0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R12: reset state at the ports
    check(bus_rdata === 32'd0, "R12 status after reset", int'(bus_rdata), 0);
    check(dac_code === 12'd0 && !dac_load && !dma_req && !irq, "R12 outputs after reset",
          int'({dac_load, dma_req, irq, dac_code}), 0);

    // R1: direct mode, right aligned, upper bits ignored
    wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 3));
    wr(1, 32'hABCD_E5A7);
    idle(8);
    check(dac_code === 12'h5A7, "R1 right align", int'(dac_code), 'h5A7);
    wr(3, 32'h1);   // R10 clear finish
    idle(2);
    // R2: left aligned, low nibble and upper half ignored
    wr(0, mk_ctrl(1, 0, 0, 1, 0, 0, 0, 2));
    wr(1, 32'h1234_987F);
    idle(8);
    check(dac_code === 12'h987, "R2 left align", int'(dac_code), 'h987);
    wr(3, 32'h0);   // R10 writing zero keeps the flag
    wr(3, 32'h1);

    // R4: software kick in triggered mode, plus kick while busy
    wr(0, mk_ctrl(0, 0, 0, 0, 1, 0, 0, 6));
    wr(1, 32'h0000_0321);
    idle(3);
    wr(2, 32'h1);
    wr(2, 32'h1);
    idle(12);
    bus_addr = 2'd2; idle(2); bus_addr = 2'd3;

    // R5: pin conditions
    wr(0, mk_ctrl(0, 0, 0, 0, 1, 1, 0, 2));   // low level repeats
    idle(20);
    ext_pin = 1; idle(6);
    wr(0, mk_ctrl(0, 0, 0, 0, 1, 1, 1, 1));   // high level
    idle(10);
    ext_pin = 0; idle(6);
    wr(0, mk_ctrl(0, 0, 0, 0, 1, 1, 3, 1));   // rising edge
    for (int k = 0; k < 3; k++) begin ext_pin = 1; idle(5); ext_pin = 0; idle(5); end
    wr(0, mk_ctrl(0, 0, 0, 0, 1, 1, 2, 1));   // falling edge
    for (int k = 0; k < 3; k++) begin ext_pin = 1; idle(5); ext_pin = 0; idle(5); end

    // R6: timers and PWM, with unselected pulses
    for (int i = 0; i < 4; i++) begin
      wr(1, 32'h100 + i);
      wr(0, mk_ctrl(0, 0, 0, 0, 1, 2 + i, 0, 1));
      pulse_tmr((i + 1) % 4); idle(3);
      pulse_pwm(i % 2); idle(3);
      pulse_tmr(i); idle(5);
    end
    for (int i = 0; i < 2; i++) begin
      wr(1, 32'h200 + i);
      wr(0, mk_ctrl(0, 0, 0, 0, 1, 6 + i, 0, 1));
      pulse_tmr(i); idle(3);
      pulse_pwm(1 - i); idle(3);
      pulse_pwm(i); idle(5);
    end

    // R7: long settle, triggers during busy ignored
    wr(1, 32'h0AA);
    wr(0, mk_ctrl(1, 0, 0, 0, 1, 2, 0, 20));
    pulse_tmr(0); idle(3);
    wr(1, 32'h055);
    pulse_tmr(0); idle(25);
    wr(3, 32'h1);

    // R8/R9: DMA requests and under-run
    wr(0, mk_ctrl(0, 1, 1, 0, 1, 3, 0, 1));
    pulse_tmr(1); idle(4);
    wr(1, 32'h777);
    idle(2);
    pulse_tmr(1); idle(4);
    pulse_tmr(1); idle(4);
    wr(3, 32'h3);
    idle(3);
    // R8: kick is not a hardware source, no request
    wr(0, mk_ctrl(0, 1, 1, 0, 1, 0, 0, 1));
    wr(2, 32'h1);
    idle(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R12 run: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule